// File: doc/BRIEF.md
# Banded-Link Automaton Element Array

This block runs a nondeterministic finite automaton over a byte stream using a row of identical state elements. Each element owns one bit per possible byte value that says whether it may be active after that byte. It also has an active flag. An element turns on when its bit for the current byte is set and either it is a start element or an active neighbour enables it over one of its nine fixed links. Those links cover relative offsets from -4 to +4, and each one is gated by a per-element mask. Any number of elements can be active together, and all of them compute their next state in parallel on every accepted byte.

The match bits of each group of consecutive elements sit together in one 256-deep memory that is as wide as the group. One lookup per group, addressed by the incoming byte, returns the bits of every element in that group. Software loads the tables, masks and flags through a write-only configuration port while no stream is running, and pulses a clear before starting a new stream. When any reporting element becomes active, a registered accept pulse follows, together with the index of the lowest such element and a flag that marks when more than one reported.

Top module: `nfa_band_array`

## Requirements
- R1: A configuration write with `cfg_kind`=0 stores bit j of `cfg_data` as element j's match bit for the byte value `cfg_addr`. An element can be active after a byte only if its match bit for that byte is 1.
- R2: A configuration write with `cfg_kind`=1 programs element `cfg_addr`. Bits [8:0] of `cfg_data` are its link mask, where bit k lets the element enable element `cfg_addr`+k-4. Bit 9 is its start flag and bit 10 is its report flag.
- R3: A start element becomes active on every accepted byte whose match bit it has set, whatever the previous state, so a match can begin at any stream position.
- R4: A non-start element becomes active on a byte only when its match bit is set and some element that was active before the byte has an enabled link to it. Offsets -4 and +4 both work.
- R5: A link that would point beyond either end of the array has no effect, and nothing wraps around.
- R6: `acc_o` goes high in the cycle after a byte is accepted, if and only if that byte leaves a reporting element active. For a chain matching "ababc", the input "abababc" gives accept only on the final byte, because overlapping partial matches are kept.
- R7: While `acc_o` is high, `idx_o` is the lowest index among the active reporting elements, and `multi_o` is 1 exactly when two or more of them are active. While `acc_o` is low, `idx_o` and `multi_o` are 0.
- R8: A byte is consumed only when `s_valid` and `s_ready` are both high. Cycles without a transfer leave the active flags unchanged and keep `acc_o` low.
- R9: A `clr` pulse clears all active flags, and `s_ready` is low during that cycle.
- R10: After reset, `acc_o`, `multi_o` and `idx_o` are 0, all active flags and masks are cleared, and `s_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear of all active flags |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 1 | 0: match-table row, 1: element control |
| cfg_addr | input | 8 | Byte value (row) or element index |
| cfg_data | input | CFG_W | Row bits or {report, start, link mask} |
| s_valid | input | 1 | Input byte valid |
| s_ready | output | 1 | Block can take a byte |
| s_data | input | 8 | Input byte |
| acc_o | output | 1 | A reporting element became active on the previous byte |
| idx_o | output | IW | Lowest reporting element index |
| multi_o | output | 1 | More than one element reported |

## Verification
A five-element chain for "ababc" is driven with the exact word, with the overlapped stream "abababc", and with a stream broken by a byte that no element matches. Together these separate correct prefix tracking from a design that either drops or keeps partial matches when a byte fails. Streams that rely only on links at offsets -4 and +4, plus an all-ones mask on the top element paired with a lone reporter at index 0, show whether the band reaches its full extent and whether links stop at the array ends. Two start elements that report on the same byte check the lowest-index choice and the multi flag. Idle gaps in the stream and a clear placed just before the final byte show that state is held when no byte arrives and dropped on a clear.

// File: rtl/nfa_band_array.sv
module nfa_band_array #(
  parameter int NUM_EL = 16,
  parameter int GRP    = 4,
  parameter int CFG_W  = (NUM_EL > 11) ? NUM_EL : 11,
  parameter int IW     = (NUM_EL > 1) ? $clog2(NUM_EL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             cfg_we,
  input  logic             cfg_kind,
  input  logic [7:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_data,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [7:0]       s_data,
  output logic             acc_o,
  output logic [IW-1:0]    idx_o,
  output logic             multi_o
);
  localparam int NGRP = NUM_EL / GRP;
  localparam int SPAN = 4;
  localparam int NLNK = 2 * SPAN + 1;

  logic [NUM_EL-1:0]           active, start, rpt, match, nxt, hit, linked;
  logic [NUM_EL-1:0][NLNK-1:0] msk, lk;
  logic [IW-1:0]               low;
  logic                        fire;

  assign s_ready = !clr;
  assign fire    = s_valid && s_ready;

  for (genvar g = 0; g < NGRP; g++) begin : g_tbl
    logic [GRP-1:0] mem [256];
    always_ff @(posedge clk)
      if (cfg_we && !cfg_kind) mem[cfg_addr] <= cfg_data[g*GRP +: GRP];
    assign match[g*GRP +: GRP] = mem[s_data];
  end

  for (genvar j = 0; j < NUM_EL; j++) begin : g_el
    for (genvar k = 0; k < NLNK; k++) begin : g_lk
      localparam int SRC = j + SPAN - k;
      if (SRC >= 0 && SRC < NUM_EL) begin : g_in
        assign lk[j][k] = active[SRC] & msk[SRC][k];
      end else begin : g_out
        assign lk[j][k] = 1'b0;
      end
    end
    assign linked[j] = |lk[j];
    assign nxt[j]    = match[j] & (linked[j] | start[j]);

    always_ff @(posedge clk)
      if (rst) begin
        msk[j]   <= '0;
        start[j] <= 1'b0;
        rpt[j]   <= 1'b0;
      end else if (cfg_we && cfg_kind && cfg_addr == 8'(j)) begin
        msk[j]   <= cfg_data[NLNK-1:0];
        start[j] <= cfg_data[9];
        rpt[j]   <= cfg_data[10];
      end
  end

  assign hit = nxt & rpt;

  always_comb begin
    low = '0;
    for (int i = NUM_EL - 1; i >= 0; i--)
      if (hit[i]) low = IW'(i);
  end

  always_ff @(posedge clk)
    if (rst || clr) active <= '0;
    else if (fire)  active <= nxt;

  always_ff @(posedge clk)
    if (rst) begin
      acc_o   <= 1'b0;
      idx_o   <= '0;
      multi_o <= 1'b0;
    end else begin
      acc_o   <= fire && (hit != '0);
      idx_o   <= fire ? low : '0;
      multi_o <= fire && ((hit & (hit - 1'b1)) != '0);
    end
endmodule

module nfa_band_array_chk #(
  parameter int IW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          clr,
  input logic          s_valid,
  input logic          s_ready,
  input logic          acc_o,
  input logic [IW-1:0] idx_o,
  input logic          multi_o
);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !(s_valid && s_ready) |=> !acc_o);
  p_multi_needs_acc_r7: assert property (@(posedge clk) disable iff (rst)
    multi_o |-> acc_o);
  p_idx_zero_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !acc_o |-> idx_o == '0);
  p_clr_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    clr |-> !s_ready);
  p_reset_quiet_r10: assert property (@(posedge clk)
    rst |=> !acc_o && !multi_o);
endmodule

bind nfa_band_array nfa_band_array_chk #(.IW(IW)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .s_valid(s_valid), .s_ready(s_ready),
  .acc_o(acc_o), .idx_o(idx_o), .multi_o(multi_o)
);

// File: tb/tb_nfa_band_array.sv
`timescale 1ns/1ps
module tb_nfa_band_array;
  localparam int N  = 16;
  localparam int CW = 16;
  localparam int IW = 4;

  logic clk = 0, rst = 1, clr = 0, cfg_we = 0, cfg_kind = 0, s_valid = 0;
  logic [7:0] cfg_addr = 0, s_data = 0;
  logic [CW-1:0] cfg_data = 0;
  logic s_ready, acc_o, multi_o;
  logic [IW-1:0] idx_o;

  int nchk = 0, nfail = 0;
  logic [N-1:0] shadow [256];

  always #2.5 clk = ~clk;

  nfa_band_array #(.NUM_EL(N), .GRP(4)) dut (
    .clk(clk), .rst(rst), .clr(clr), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .acc_o(acc_o), .idx_o(idx_o),
    .multi_o(multi_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_wr(input bit kind, input int addr, input int data);
    @(negedge clk);
    cfg_we = 1; cfg_kind = kind; cfg_addr = 8'(addr); cfg_data = CW'(data);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic load_rows();
    for (int r = 0; r < 256; r++) cfg_wr(0, r, int'(shadow[r]));
  endtask

  task automatic wipe();
    for (int r = 0; r < 256; r++) shadow[r] = '0;
    load_rows();
    for (int e = 0; e < N; e++) cfg_wr(1, e, 0);
    pulse_clr();
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1;
    #1 chk(s_ready == 0, "R9 ready low in clear", s_ready, 0);
    @(negedge clk); clr = 0;
  endtask

  task automatic sym(input byte c, input bit ea, input int ei, input bit em, input string req);
    @(negedge clk);
    s_valid = 1; s_data = c;
    @(posedge clk); #1;
    s_valid = 0;
    chk(acc_o == ea, req, acc_o, ea);
    chk(idx_o == IW'(ea ? ei : 0), {req, " idx"}, idx_o, ea ? ei : 0);
    chk(multi_o == em, {req, " multi"}, multi_o, em);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      chk(acc_o == 0, "R8 idle keeps accept low", acc_o, 0);
    end
  endtask

  task automatic setup_ababc();
    wipe();
    shadow["a"] = 16'h0005; shadow["b"] = 16'h000A; shadow["c"] = 16'h0010;
    load_rows();
    cfg_wr(1, 0, 'h220);
    for (int e = 1; e < 4; e++) cfg_wr(1, e, 'h020);
    cfg_wr(1, 4, 'h400);
    pulse_clr();
  endtask

  task automatic t_reset();
    chk(acc_o == 0, "R10 reset accept", acc_o, 0);
    chk(idx_o == 0, "R10 reset idx", idx_o, 0);
    chk(multi_o == 0, "R10 reset multi", multi_o, 0);
    chk(s_ready == 1, "R10 reset ready", s_ready, 1);
  endtask

  task automatic t_overlap();
    setup_ababc();
    sym("a", 0, 0, 0, "R6 a");
    sym("b", 0, 0, 0, "R6 ab");
    sym("a", 0, 0, 0, "R6 aba");
    sym("b", 0, 0, 0, "R6 abab");
    sym("a", 0, 0, 0, "R6 ababa");
    sym("b", 0, 0, 0, "R6 ababab");
    sym("c", 1, 4, 0, "R6 abababc final accept");
    sym("c", 0, 0, 0, "R3 lone c no accept");
  endtask

  task automatic t_gate();
    setup_ababc();
    sym("a", 0, 0, 0, "R1 a");
    sym("b", 0, 0, 0, "R1 ab");
    sym("a", 0, 0, 0, "R1 aba");
    sym("d", 0, 0, 0, "R1 unmatched byte");
    sym("b", 0, 0, 0, "R1 b after break");
    sym("c", 0, 0, 0, "R1 chain lost");
    sym("a", 0, 0, 0, "R3 restart a");
    sym("b", 0, 0, 0, "R3 restart b");
    sym("a", 0, 0, 0, "R3 restart a2");
    sym("b", 0, 0, 0, "R3 restart b2");
    sym("c", 1, 4, 0, "R3 restart accept");
  endtask

  task automatic t_stall_clear();
    setup_ababc();
    sym("a", 0, 0, 0, "R8 a");
    sym("b", 0, 0, 0, "R8 ab");
    idle(3);
    sym("a", 0, 0, 0, "R8 aba");
    sym("b", 0, 0, 0, "R8 abab");
    idle(2);
    sym("c", 1, 4, 0, "R8 accept after gaps");
    sym("a", 0, 0, 0, "R9 a");
    sym("b", 0, 0, 0, "R9 ab");
    sym("a", 0, 0, 0, "R9 aba");
    sym("b", 0, 0, 0, "R9 abab");
    pulse_clr();
    sym("c", 0, 0, 0, "R9 cleared before c");
  endtask

  task automatic t_band();
    wipe();
    shadow["p"] = 16'h0004; shadow["q"] = 16'h0040; shadow["r"] = 16'h0400;
    load_rows();
    cfg_wr(1, 2, 'h300);
    cfg_wr(1, 10, 'h201);
    cfg_wr(1, 6, 'h400);
    pulse_clr();
    sym("p", 0, 0, 0, "R4 p");
    sym("q", 1, 6, 0, "R4 offset +4");
    sym("r", 0, 0, 0, "R4 r");
    sym("q", 1, 6, 0, "R4 offset -4");
    sym("q", 0, 0, 0, "R4 no link no accept");
  endtask

  task automatic t_edge();
    wipe();
    shadow["x"] = 16'h8000; shadow["y"] = 16'h0001; shadow["w"] = 16'h0800;
    load_rows();
    cfg_wr(1, 15, 'h3FF);
    cfg_wr(1, 0, 'h5FF);
    cfg_wr(1, 11, 'h400);
    pulse_clr();
    sym("x", 0, 0, 0, "R5 x top");
    sym("y", 0, 0, 0, "R5 no wrap to 0");
    sym("x", 0, 0, 0, "R5 x again");
    sym("w", 1, 11, 0, "R2 mask bit0 reaches -4");
  endtask

  task automatic t_multi();
    wipe();
    shadow["z"] = 16'h0208; shadow["k"] = 16'h0200;
    load_rows();
    cfg_wr(1, 3, 'h600);
    cfg_wr(1, 9, 'h600);
    pulse_clr();
    sym("z", 1, 3, 1, "R7 two reporters");
    sym("k", 1, 9, 0, "R7 single reporter");
    sym("m", 0, 0, 0, "R7 none");
  endtask

  initial begin
    #100000;
    nfail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    @(negedge clk); rst = 0;
    t_overlap();
    t_gate();
    t_stall_clear();
    t_band();
    t_edge();
    t_multi();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule